// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel audio samples, taken from a first-word-fall-through transmit FIFO, into a serial data line and a frame signal. The bit rate comes from outside as a one-cycle `bit_tick` enable. Each enable emits exactly one bit. A frame is built from 32-bit slots, two per stereo pair, and holds 2, 4, 6 or 8 channels. The same serializer produces standard I2S, left-justified, right-justified and PCM short-sync framing. In PCM framing the delay from the sync pulse to the first data bit can be set from 0 to 3 bit periods.

Software sets the format fields while `tx_start` is low and then raises `tx_start` to begin. The block reads one FIFO word at the first bit of every slot. The sample sits in the low bits of that word and goes out MSB first. The slot bits around the sample are zero. If the FIFO is empty when a slot begins, that slot carries zeros and a sticky underrun flag is set.

Top module: `audio_serial_tx`

## Requirements
- R1: While `tx_start` is low, `sdo`, `ws` and `underrun` are 0 from the next clock edge. Raising `tx_start` restarts the frame at slot 0, bit 0.
- R2: While `tx_start` is high, each clock edge with `bit_tick` high emits the next frame bit, and `sdo`/`ws` take it at that edge. On edges without `bit_tick`, `sdo` and `ws` hold.
- R3: A frame has 2*(`chan_code`+1) slots of 32 bits each. One FIFO word is popped (`fifo_rd` high with `bit_tick`) at bit 0 of every slot, provided the FIFO is not empty. The sample is the low w bits of the word, where w = `width_m1`+1.
- R4: Within its window the sample goes out MSB first. Every slot bit outside the window is 0, and so is any sample bit pushed past bit 31 of the slot.
- R5: With `fmt_pcm`=0, `ws` is 0 during slots 0 to `chan_code` and 1 during the remaining slots. Standard I2S (`just_mode`=0) puts the MSB at bit 1 of the slot, one bit after the `ws` edge.
- R6: Left-justified framing (`just_mode`=1, and also the code 3) puts the MSB at bit 0 of the slot, coinciding with the `ws` edge.
- R7: Right-justified framing (`just_mode`=2) puts the sample LSB at bit 31 of the slot.
- R8: With `fmt_pcm`=1, `ws` is 1 only during bit 0 of slot 0, and the MSB of every slot is at bit `pcm_delay` (0 to 3). `just_mode` is ignored in this framing.
- R9: If the FIFO is empty at bit 0 of a slot, that slot sends zeros, no pop is made and `underrun` goes to 1. `underrun` stays at 1 until `tx_start` is low.
- R10: The format fields are captured on every clock edge at which `tx_start` is low. Changing them while `tx_start` is high has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle bit-period enable |
| tx_start | input | 1 | Run enable; 0 stops and clears |
| fmt_pcm | input | 1 | 0 = I2S-style framing, 1 = PCM short-sync framing |
| just_mode | input | 2 | 0 standard I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| pcm_delay | input | 2 | PCM sync-to-MSB delay in bit periods |
| width_m1 | input | 5 | Sample width minus one |
| chan_code | input | 2 | Channel count code: 2*(code+1) channels |
| fifo_data | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| sdo | output | 1 | Serial data |
| ws | output | 1 | Word-select / frame-sync |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
Every bit is due at the first clock edge that samples `bit_tick` high. The bench raises `bit_tick` for one cycle and compares `sdo`, `ws` and `underrun` at the next falling edge. For part of the bits it checks again one cycle later with no tick, to confirm the outputs hold. Stopping takes effect at the first edge with `tx_start` low, and the quiet outputs are checked at the falling edge after it. The format inputs are set one full cycle before `tx_start` rises, so they are captured at the last stopped edge.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    JUST_STD   = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_RIGHT = 2'd2,
    JUST_LEFT2 = 2'd3
  } just_e;

  typedef struct packed {
    logic       pcm;
    just_e      just;
    logic [1:0] dly;
  } tx_fmt_t;

endpackage

// File: rtl/atx_slot_counter.sv
module atx_slot_counter #(
  parameter int SLOT_W    = 32,
  parameter int CHAN_BITS = 2,
  localparam int BIT_W    = $clog2(SLOT_W),
  localparam int SLOT_IW  = CHAN_BITS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               adv,
  input  logic [SLOT_IW-1:0] slot_last,
  output logic [BIT_W-1:0]   bit_idx,
  output logic [SLOT_IW-1:0] slot_idx
);

  logic bit_wrap;
  assign bit_wrap = (bit_idx == BIT_W'(SLOT_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (adv) begin
      if (bit_wrap) begin
        bit_idx  <= '0;
        slot_idx <= (slot_idx == slot_last) ? '0 : slot_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/atx_bit_pick.sv
module atx_bit_pick
  import audio_tx_pkg::*;
#(
  parameter int SLOT_W = 32,
  parameter int DATA_W = 32,
  localparam int WW    = $clog2(DATA_W),
  localparam int BIT_W = $clog2(SLOT_W),
  localparam int PW    = BIT_W + 1
) (
  input  tx_fmt_t           fmt,
  input  logic [WW-1:0]     width_m1,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] word,
  output logic              bit_val
);

  logic [PW-1:0]     width;
  logic [PW-1:0]     offset;
  logic [PW-1:0]     pos;
  logic [PW-1:0]     rel;
  logic [PW-1:0]     src;
  logic [DATA_W-1:0] shifted;
  logic              in_win;

  always_comb begin
    width = PW'(width_m1) + 1'b1;
    pos   = PW'(bit_idx);
    if (fmt.pcm) begin
      offset = PW'(fmt.dly);
    end else begin
      case (fmt.just)
        JUST_STD:   offset = PW'(1);
        JUST_RIGHT: offset = PW'(SLOT_W) - width;
        default:    offset = '0;
      endcase
    end
    rel     = pos - offset;
    in_win  = (pos >= offset) && (rel < width);
    src     = width - 1'b1 - rel;
    shifted = word >> src;
    bit_val = in_win & shifted[0];
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int SLOT_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CHAN_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bit_tick,
  input  logic                      tx_start,
  input  logic                      fmt_pcm,
  input  logic [1:0]                just_mode,
  input  logic [1:0]                pcm_delay,
  input  logic [$clog2(DATA_W)-1:0] width_m1,
  input  logic [CHAN_BITS-1:0]      chan_code,
  input  logic [DATA_W-1:0]         fifo_data,
  input  logic                      fifo_empty,
  output logic                      fifo_rd,
  output logic                      sdo,
  output logic                      ws,
  output logic                      underrun
);

  localparam int WW      = $clog2(DATA_W);
  localparam int BIT_W   = $clog2(SLOT_W);
  localparam int SLOT_IW = CHAN_BITS + 1;

  tx_fmt_t              fmt_q;
  logic [WW-1:0]        width_q;
  logic [CHAN_BITS-1:0] chan_q;
  logic [DATA_W-1:0]    sample_q;
  logic [BIT_W-1:0]     bit_idx;
  logic [SLOT_IW-1:0]   slot_idx;
  logic [DATA_W-1:0]    fresh_word;
  logic [DATA_W-1:0]    cur_word;
  logic                 slot_first;
  logic                 emit;
  logic                 bit_val;
  logic                 ws_next;
  logic                 sdo_q, ws_q, underrun_q;
  logic                 pcm_run;

  assign emit       = tx_start & bit_tick;
  assign slot_first = (bit_idx == '0);
  assign fresh_word = fifo_empty ? '0 : fifo_data;
  assign cur_word   = slot_first ? fresh_word : sample_q;
  assign fifo_rd    = emit & slot_first & ~fifo_empty;
  assign pcm_run    = fmt_q.pcm;

  atx_slot_counter #(
    .SLOT_W    (SLOT_W),
    .CHAN_BITS (CHAN_BITS)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clear     (~tx_start),
    .adv       (emit),
    .slot_last ({chan_q, 1'b1}),
    .bit_idx   (bit_idx),
    .slot_idx  (slot_idx)
  );

  atx_bit_pick #(
    .SLOT_W (SLOT_W),
    .DATA_W (DATA_W)
  ) u_pick (
    .fmt      (fmt_q),
    .width_m1 (width_q),
    .bit_idx  (bit_idx),
    .word     (cur_word),
    .bit_val  (bit_val)
  );

  always_comb begin
    if (fmt_q.pcm) begin
      ws_next = (slot_idx == '0) && slot_first;
    end else begin
      ws_next = (slot_idx > {1'b0, chan_q});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q      <= '0;
      width_q    <= '0;
      chan_q     <= '0;
      sample_q   <= '0;
      sdo_q      <= 1'b0;
      ws_q       <= 1'b0;
      underrun_q <= 1'b0;
    end else if (!tx_start) begin
      fmt_q      <= '{pcm: fmt_pcm, just: just_e'(just_mode), dly: pcm_delay};
      width_q    <= width_m1;
      chan_q     <= chan_code;
      sample_q   <= '0;
      sdo_q      <= 1'b0;
      ws_q       <= 1'b0;
      underrun_q <= 1'b0;
    end else if (bit_tick) begin
      sdo_q <= bit_val;
      ws_q  <= ws_next;
      if (slot_first) begin
        sample_q <= fresh_word;
        if (fifo_empty) underrun_q <= 1'b1;
      end
    end
  end

  assign sdo      = sdo_q;
  assign ws       = ws_q;
  assign underrun = underrun_q;

endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic tx_start,
  input logic fifo_empty,
  input logic fifo_rd,
  input logic sdo,
  input logic ws,
  input logic underrun,
  input logic pcm_mode
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_start |=> (!sdo && !ws && !underrun));

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !bit_tick) |=> ($stable(sdo) && $stable(ws)));

  p_pop_legal_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> (bit_tick && tx_start && !fifo_empty));

  p_sync_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (pcm_mode && ws && tx_start && bit_tick) |=> !ws);

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (underrun && tx_start) |=> underrun);

  p_underrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(bit_tick && fifo_empty && tx_start));

endmodule

bind audio_serial_tx audio_serial_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_tick   (bit_tick),
  .tx_start   (tx_start),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .sdo        (sdo),
  .ws         (ws),
  .underrun   (underrun),
  .pcm_mode   (pcm_run)
);

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        tx_start = 1'b0;
  logic        fmt_pcm = 1'b0;
  logic [1:0]  just_mode = 2'd0;
  logic [1:0]  pcm_delay = 2'd0;
  logic [4:0]  width_m1 = 5'd15;
  logic [1:0]  chan_code = 2'd0;
  logic [31:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_rd;
  logic        sdo, ws, underrun;

  int          rd_idx;
  int          avail = 0;
  int          seed = 0;
  logic        fifo_clr = 1'b0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] fifo_word(int i, int s);
    return ((i + s * 17) * 32'h9E3779B1) ^ 32'h5A5A0FF0;
  endfunction

  always_ff @(posedge clk) begin
    if (fifo_clr) rd_idx <= 0;
    else if (fifo_rd) rd_idx <= rd_idx + 1;
  end

  assign fifo_empty = (rd_idx >= avail);
  assign fifo_data  = fifo_word(rd_idx, seed);

  audio_serial_tx u_audio_serial_tx (
    .clk (clk), .rst (rst), .bit_tick (bit_tick), .tx_start (tx_start),
    .fmt_pcm (fmt_pcm), .just_mode (just_mode), .pcm_delay (pcm_delay),
    .width_m1 (width_m1), .chan_code (chan_code), .fifo_data (fifo_data),
    .fifo_empty (fifo_empty), .fifo_rd (fifo_rd), .sdo (sdo), .ws (ws),
    .underrun (underrun)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int bit_offset(logic pcm, logic [1:0] jm, logic [1:0] dl, int w);
    if (pcm) return int'(dl);
    if (jm == 2'd0) return 1;
    if (jm == 2'd2) return 32 - w;
    return 0;
  endfunction

  // One configuration: set fields, start, check every bit of nfr frames.
  task automatic run_cfg(input logic pcm, input logic [1:0] jm, input logic [1:0] dl,
                         input int w, input int cc, input int nfr, input int have,
                         input bit scramble);
    int nch;
    int off;
    nch = 2 * (cc + 1);
    off = bit_offset(pcm, jm, dl, w);
    @(negedge clk);
    fmt_pcm = pcm; just_mode = jm; pcm_delay = dl;
    width_m1 = 5'(w - 1); chan_code = 2'(cc);
    avail = have; seed = seed + 1; fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    tx_start = 1'b1;
    if (scramble) begin
      fmt_pcm = ~pcm; just_mode = jm + 2'd1; pcm_delay = dl + 2'd3;
      width_m1 = 5'(w - 9); chan_code = 2'(cc + 3);
    end
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < nch; s++) begin
        for (int b = 0; b < 32; b++) begin
          int          g;
          logic [31:0] wd;
          logic        eb, ew, eu;
          bit          inwin;
          string       tg;
          g     = f * nch + s;
          wd    = (g < have) ? fifo_word(g, seed) : 32'd0;
          inwin = (b >= off) && (b - off < w);
          eb    = inwin ? wd[w - 1 - (b - off)] : 1'b0;
          ew    = pcm ? (g == f * nch && s == 0 && b == 0) : (s > cc);
          eu    = (g >= have) || (f * nch + nch > have && f > 0 && have < nfr * nch && (nch * f) > have);
          eu    = 1'b0;
          for (int k = 0; k <= g; k++) if (k >= have) eu = 1'b1;
          if (!inwin) tg = "R4";
          else if (scramble) tg = "R10";
          else if (pcm) tg = "R8";
          else if (jm == 2'd2) tg = "R7";
          else if (jm == 2'd0) tg = "R5";
          else tg = "R6";
          @(negedge clk);
          bit_tick = 1'b1;
          @(negedge clk);
          bit_tick = 1'b0;
          chk(sdo === eb, tg, $sformatf("sdo f%0d s%0d b%0d", f, s, b), 32'(sdo), 32'(eb));
          chk(ws === ew, pcm ? "R8" : "R5", $sformatf("ws f%0d s%0d b%0d", f, s, b), 32'(ws), 32'(ew));
          chk(underrun === eu, "R9", $sformatf("underrun f%0d s%0d b%0d", f, s, b),
              32'(underrun), 32'(eu));
          if (b < 3) begin
            @(negedge clk);
            chk(sdo === eb && ws === ew, "R2", "hold without tick",
                {30'd0, ws, sdo}, {30'd0, ew, eb});
          end
        end
      end
    end
    // R3: pops equal the slots that found a word
    chk(rd_idx == ((have < nfr * nch) ? have : nfr * nch), "R3", "pop count",
        32'(rd_idx), 32'((have < nfr * nch) ? have : nfr * nch));
    @(negedge clk);
    tx_start = 1'b0;
    if (scramble) begin
      fmt_pcm = pcm; just_mode = jm; pcm_delay = dl; width_m1 = 5'(w - 1); chan_code = 2'(cc);
    end
    @(negedge clk);
    chk(sdo === 1'b0 && ws === 1'b0 && underrun === 1'b0, "R1", "quiet after stop",
        {29'd0, underrun, ws, sdo}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdo === 1'b0 && ws === 1'b0 && underrun === 1'b0 && fifo_rd === 1'b0, "R1",
        "reset state", {28'd0, fifo_rd, underrun, ws, sdo}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // Sweep: 4 justification codes and 4 PCM delays, each width with its own channel code
    for (int m = 0; m < 8; m++) begin
      for (int wi = 0; wi < 4; wi++) begin
        int w;
        w = 8 * (wi + 1);
        run_cfg(m >= 4, 2'(m), 2'(m - 4), w, wi, 2, 2 * 2 * (wi + 1), 1'b0);
      end
    end
    // R9: FIFO runs dry mid-stream
    run_cfg(1'b0, 2'd1, 2'd0, 16, 0, 2, 3, 1'b0);
    run_cfg(1'b1, 2'd0, 2'd2, 24, 1, 1, 0, 1'b0);
    // R10: inputs changed while running are ignored
    run_cfg(1'b0, 2'd0, 2'd0, 16, 0, 2, 4, 1'b1);
    run_cfg(1'b1, 2'd2, 2'd1, 20, 2, 1, 6, 1'b1);
    finish_run();
  end

endmodule